// File: doc/BRIEF.md
# Video Memory Wait-State Arbiter

This block sits between an 8-bit processor bus and a video memory that the display logic shares with the processor. A free-running counter, clocked by the processor clock, marks out each display line. The last stretch of every line is the horizontal blanking window, and only during that window may the processor touch video memory. The window is 80 cycles long at the 50 Hz rate and 60 cycles long at the 60 Hz rate.

Stalls are decided one T-state at a time, at the moment an access is actually on the bus. When a video access appears outside the window, the active-low wait output goes low at once, so the processor stretches that very T-state. Wait returns high in the first cycle of blanking, and the access then completes inside the window. Instructions are never held back as a whole. An opcode fetch from ordinary memory therefore runs freely, even when the instruction goes on to touch video memory. An opcode fetch whose address lies in video memory counts as a video access and is stalled like any other. Every ROM access receives a fixed wait state, whatever the blanking state.

Top module: `vram_wait_arbiter`

## Requirements
- R1: Each line lasts LINE_CYCLES clock cycles. `hblank` is high during the last W cycles of each line. After the k-th rising edge that follows reset release, `hblank` equals ((k mod LINE_CYCLES) >= LINE_CYCLES - W).
- R2: The window length W is set by `rate_60`. W is WIN_50HZ (default 80) when `rate_60` is 0, and WIN_60HZ (default 60) when `rate_60` is 1.
- R3: A video read or write started in a cycle whose line phase p is below LINE_CYCLES - W holds `wait_n` low for exactly (LINE_CYCLES - W - p) cycles. `wait_n` goes high in the first blanking cycle.
- R4: A video access started while `hblank` is high gets no wait state, and `vram_grant` is high in its first cycle.
- R5: A video access that was granted inside the window keeps `vram_grant` high and `wait_n` high until it ends, even after the window closes. A new video access that starts after the window has closed is stalled.
- R6: An opcode fetch (`m1_n` low) from video memory is stalled exactly as in R3. An opcode fetch from ordinary memory (neither select high) never lowers `wait_n`, whatever the line phase.
- R7: Every ROM access gets exactly one wait state, in its first cycle, whether or not blanking is active.
- R8: While reset is held and right after its release, the line counter is 0, `hblank` is low, `wait_n` is high and `vram_grant` is low.
- R9: A bus cycle counts as an access only when `mreq_n` is low and at least one of `rd_n`, `wr_n` or `m1_n` is low. A cycle with `mreq_n` low and all three strobes high (a refresh) causes no wait and no grant, even when `vram_sel` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock, one T-state per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_60 | input | 1 | 0 selects the 50 Hz window, 1 selects the 60 Hz window |
| mreq_n | input | 1 | Memory request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| m1_n | input | 1 | Opcode fetch indicator, active low |
| vram_sel | input | 1 | Address decode: video memory |
| rom_sel | input | 1 | Address decode: ROM |
| wait_n | output | 1 | Wait request to the processor, active low |
| hblank | output | 1 | Horizontal blanking window active |
| vram_grant | output | 1 | Video memory is granted to the processor this cycle |

## Verification
On every cycle, the assertions check the following: blanking opens at the right counter value and closes at line wrap; a stalled video access is released only by blanking; a granted access keeps its grant until it ends; ROM stalls fall on the first cycle of the access and never return; plain memory never sees a wait. The exact number of wait states for each start phase, in both window lengths, can only be shown by the bench's sweep over every line phase. The same holds for the carry-over case, in which the window closes during an access and a second access must wait again.

// File: rtl/vwa_pkg.sv
package vwa_pkg;

   // Decoded view of one bus T-state
   typedef struct packed {
      logic active;   // a real memory access (not a refresh)
      logic vram;     // access targets video memory
      logic rom;      // access targets ROM
   } bus_req_t;

endpackage

// File: rtl/vwa_bus_decode.sv
module vwa_bus_decode
   import vwa_pkg::*;
(
   input  logic     mreq_n,
   input  logic     rd_n,
   input  logic     wr_n,
   input  logic     m1_n,
   input  logic     vram_sel,
   input  logic     rom_sel,
   output bus_req_t req
);

   logic act;

   // A refresh drives mreq without any strobe; it must not count
   assign act = !mreq_n && (!rd_n || !wr_n || !m1_n);

   always_comb begin
      req.active = act;
      req.vram   = act && vram_sel;
      req.rom    = act && rom_sel && !vram_sel;
   end

endmodule

// File: rtl/vwa_line_timer.sv
module vwa_line_timer #(
   parameter int LINE_CYCLES = 228,
   parameter int WIN_50HZ    = 80,
   parameter int WIN_60HZ    = 60
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rate_60,
   output logic blank_q
);

   localparam int CW = $clog2(LINE_CYCLES);
   localparam logic [CW-1:0] LAST      = CW'(LINE_CYCLES - 1);
   localparam logic [CW-1:0] OPEN_50HZ = CW'(LINE_CYCLES - WIN_50HZ);
   localparam logic [CW-1:0] OPEN_60HZ = CW'(LINE_CYCLES - WIN_60HZ);

   initial begin
      assert (LINE_CYCLES > WIN_50HZ && LINE_CYCLES > WIN_60HZ)
         else $error("line must be longer than either blanking window");
      assert (WIN_50HZ > 0 && WIN_60HZ > 0)
         else $error("blanking windows must be non-empty");
   end

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_d;
   logic [CW-1:0] open_at;

   always_comb begin
      cnt_d   = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      open_at = rate_60 ? OPEN_60HZ : OPEN_50HZ;
   end

   // blank flag is registered together with the counter so it aligns with it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         blank_q <= 1'b0;
      end else begin
         cnt_q   <= cnt_d;
         blank_q <= (cnt_d >= open_at);
      end
   end

   // R1: the window opens exactly at the programmed phase
   a_r1_opens_on_time: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(blank_q) |-> (cnt_q == open_at));

   // R1: the window closes as the line wraps
   a_r1_closes_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == LAST) |=> ((cnt_q == '0) && !blank_q));

endmodule

// File: rtl/vwa_vram_gate.sv
module vwa_vram_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic vram_req,
   input  logic blank,
   output logic stall,
   output logic grant
);

   logic held_q;

   // Decided per T-state: granted in the window, or carried over from a
   // grant the same access already had
   assign grant = vram_req && (blank || held_q);
   assign stall = vram_req && !grant;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held_q <= 1'b0;
      else        held_q <= grant;
   end

   // R3: a stalled access is released only by the window
   a_r3_release_only_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> (!vram_req || stall || blank));

   // R3: the first blanking cycle lets a waiting access through
   a_r3_release_on_open: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(blank) && vram_req) |-> grant);

   // R5: a granted access keeps its grant until it ends
   a_r5_held_to_end: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && vram_req) |=> (!vram_req || grant));

endmodule

// File: rtl/vwa_rom_wait.sv
module vwa_rom_wait #(
   parameter int ROM_WAITS = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rom_req,
   output logic rom_stall
);

   initial begin
      assert (ROM_WAITS >= 0 && ROM_WAITS < 16)
         else $error("ROM wait count out of range");
   end

   generate
      if (ROM_WAITS == 0) begin : g_none
         assign rom_stall = 1'b0;
      end else begin : g_count
         localparam int WW = $clog2(ROM_WAITS + 1);
         localparam logic [WW-1:0] LIMIT = WW'(ROM_WAITS);

         logic [WW-1:0] served_q;

         assign rom_stall = rom_req && (served_q < LIMIT);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         served_q <= '0;
            else if (!rom_req)  served_q <= '0;
            else if (rom_stall) served_q <= served_q + 1'b1;
         end

         // R7: the first T-state of a ROM access is stretched
         a_r7_first_state_waits: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rom_req) |-> rom_stall);

         // R7: once released, a ROM access is never stalled again
         a_r7_no_restall: assert property (@(posedge clk) disable iff (!rst_n)
            (rom_req && !rom_stall) |=> (!rom_req || !rom_stall));
      end
   endgenerate

endmodule

// File: rtl/vram_wait_arbiter.sv
module vram_wait_arbiter
   import vwa_pkg::*;
#(
   parameter int LINE_CYCLES = 228,
   parameter int WIN_50HZ    = 80,
   parameter int WIN_60HZ    = 60,
   parameter int ROM_WAITS   = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rate_60,
   input  logic mreq_n,
   input  logic rd_n,
   input  logic wr_n,
   input  logic m1_n,
   input  logic vram_sel,
   input  logic rom_sel,
   output logic wait_n,
   output logic hblank,
   output logic vram_grant
);

   bus_req_t req;
   logic     blank;
   logic     vram_stall;
   logic     rom_stall;

   vwa_bus_decode u_decode (
      .mreq_n   (mreq_n),
      .rd_n     (rd_n),
      .wr_n     (wr_n),
      .m1_n     (m1_n),
      .vram_sel (vram_sel),
      .rom_sel  (rom_sel),
      .req      (req)
   );

   vwa_line_timer #(
      .LINE_CYCLES (LINE_CYCLES),
      .WIN_50HZ    (WIN_50HZ),
      .WIN_60HZ    (WIN_60HZ)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .rate_60 (rate_60),
      .blank_q (blank)
   );

   vwa_vram_gate u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .vram_req (req.vram),
      .blank    (blank),
      .stall    (vram_stall),
      .grant    (vram_grant)
   );

   vwa_rom_wait #(
      .ROM_WAITS (ROM_WAITS)
   ) u_rom (
      .clk       (clk),
      .rst_n     (rst_n),
      .rom_req   (req.rom),
      .rom_stall (rom_stall)
   );

   assign wait_n = !(vram_stall || rom_stall);
   assign hblank = blank;

   // R6: accesses to ordinary memory never wait
   a_r6_plain_never_waits: assert property (@(posedge clk) disable iff (!rst_n)
      (!vram_sel && !rom_sel) |-> wait_n);

   // R9: a refresh never draws a grant or a wait
   a_r9_refresh_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_n && wr_n && m1_n) |-> (wait_n && !vram_grant));

endmodule

// File: tb/test_vram_wait_arbiter.sv
`timescale 1ns/100ps
module test_vram_wait_arbiter;

   localparam int L   = 96;
   localparam int W50 = 80;
   localparam int W60 = 60;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rate_60 = 1'b0;
   logic mreq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, m1_n = 1'b1;
   logic vram_sel = 1'b0, rom_sel = 1'b0;
   logic wait_n, hblank, vram_grant;

   int vecs = 0;
   int errs = 0;
   int cyc;
   int win;

   always #2.5 clk = ~clk;

   vram_wait_arbiter #(
      .LINE_CYCLES (L),
      .WIN_50HZ    (W50),
      .WIN_60HZ    (W60),
      .ROM_WAITS   (1)
   ) i_vram_wait_arbiter (
      .clk        (clk),
      .rst_n      (rst_n),
      .rate_60    (rate_60),
      .mreq_n     (mreq_n),
      .rd_n       (rd_n),
      .wr_n       (wr_n),
      .m1_n       (m1_n),
      .vram_sel   (vram_sel),
      .rom_sel    (rom_sel),
      .wait_n     (wait_n),
      .hblank     (hblank),
      .vram_grant (vram_grant)
   );

   // Rising edges since reset release = line position reference
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      vecs++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: got %0d, expected %0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   task automatic bus_idle();
      mreq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; m1_n = 1'b1;
      vram_sel = 1'b0; rom_sel = 1'b0;
   endtask

   task automatic do_reset(input bit fast);
      @(negedge clk);
      bus_idle();
      rst_n   = 1'b0;
      rate_60 = fast;
      win     = fast ? W60 : W50;
      repeat (3) @(negedge clk);
      #1;
      check(wait_n == 1'b1, "R8 wait_n in reset", wait_n, 1);
      check(hblank == 1'b0, "R8 hblank in reset", hblank, 0);
      check(vram_grant == 1'b0, "R8 grant in reset", vram_grant, 0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(hblank == 1'b0 && wait_n == 1'b1, "R8 state after release",
            {hblank, wait_n}, 1);
   endtask

   task automatic goto_phase(input int p);
      @(negedge clk);
      while ((cyc % L) != p) @(negedge clk);
   endtask

   // count the cycles wait_n stays low for the access now on the bus
   task automatic count_waits(output int n);
      n = 0;
      #1;
      while (!wait_n && n < 2 * L) begin
         n++;
         @(negedge clk);
         #1;
      end
   endtask

   task automatic vram_trial(input bit fetch, input bit write);
      int p, exp, n;
      p   = cyc % L;
      exp = (p >= L - win) ? 0 : (L - win - p);
      mreq_n = 1'b0; vram_sel = 1'b1;
      if (fetch) begin m1_n = 1'b0; rd_n = 1'b0; end
      else if (write) wr_n = 1'b0;
      else rd_n = 1'b0;
      count_waits(n);
      if (fetch)         check(n == exp, "R6 video opcode fetch waits", n, exp);
      else if (exp == 0) check(n == 0, "R4 no wait inside window", n, 0);
      else               check(n == exp, "R3 video wait count", n, exp);
      check(vram_grant == 1'b1, "R4 grant when released", vram_grant, 1);
      @(negedge clk);
      bus_idle();
   endtask

   task automatic rom_trial();
      int n;
      mreq_n = 1'b0; rd_n = 1'b0; rom_sel = 1'b1;
      count_waits(n);
      check(n == 1, "R7 single ROM wait", n, 1);
      @(negedge clk); #1;
      check(wait_n == 1'b1, "R7 ROM access not re-stalled", wait_n, 1);
      @(negedge clk);
      bus_idle();
   endtask

   task automatic plain_and_refresh();
      mreq_n = 1'b0; rd_n = 1'b0; m1_n = 1'b0;
      #1;
      check(wait_n == 1'b1, "R6 plain opcode fetch never waits", wait_n, 1);
      @(negedge clk);
      bus_idle();
      mreq_n = 1'b0; vram_sel = 1'b1;
      #1;
      check(wait_n == 1'b1 && vram_grant == 1'b0, "R9 refresh ignored",
            {wait_n, vram_grant}, 2);
      @(negedge clk);
      bus_idle();
   endtask

   task automatic sweep_blank(input string req);
      for (int k = 0; k < 2 * L; k++) begin
         int p;
         @(negedge clk); #1;
         p = cyc % L;
         check(hblank == (p >= L - win), req, hblank, int'(p >= L - win));
      end
   endtask

   task automatic carry_over();
      int n, exp;
      goto_phase(L - 1);
      mreq_n = 1'b0; wr_n = 1'b0; vram_sel = 1'b1;
      for (int k = 0; k < 3; k++) begin
         #1;
         check(wait_n == 1'b1 && vram_grant == 1'b1, "R5 held access keeps grant",
               {wait_n, vram_grant}, 3);
         @(negedge clk);
      end
      bus_idle();
      @(negedge clk);
      exp = L - win - (cyc % L);
      mreq_n = 1'b0; rd_n = 1'b0; vram_sel = 1'b1;
      count_waits(n);
      check(n == exp, "R5 new access after window stalls", n, exp);
      @(negedge clk);
      bus_idle();
   endtask

   task automatic run_mode(input bit fast);
      do_reset(fast);
      sweep_blank(fast ? "R2 60Hz window" : "R1 50Hz window");
      for (int p = 0; p < L; p++) begin
         goto_phase(p);
         vram_trial(1'b0, p[0]);
         rom_trial();
         plain_and_refresh();
      end
      for (int p = 0; p < L - win; p += 7) begin
         goto_phase(p);
         vram_trial(1'b1, 1'b0);
      end
      carry_over();
   endtask

   initial begin
      #(200000 * 5);
      errs++;
      $display("FAIL watchdog: got 0, expected 1 (run finished)");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin
      run_mode(1'b0);
      run_mode(1'b1);
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

endmodule